// File: doc/BRIEF.md
# Smart-Card Speed Negotiation Tracker

This block sits beside a passive smart-card line receiver. It reads every character the receiver reports, in either direction, because a tap on the shared I/O wire cannot tell the directions apart. After each session-opening reset it skips the card's answer-to-reset. It then follows the protocol parameter selection (PPS) request and the card's reply to it.

When both messages are well formed and the reply confirms the requested speed byte, the block changes the receiver's elementary-time-unit (etu) sampling counts itself. The new counts take effect on the clock edge that accepts the reply's final check byte, so the next character is already sampled at the new rate. Host software would react far too late to do this.

Any malformed character or out-of-protocol byte puts the block into a dormant state. A correct reply also ends in that state. The block leaves it only on the next reset rising edge.

Top module: `pps_catcher`

## Requirements
- R1: After `rst`, and on the clock edge that samples `sim_rst_rise` high, the counts return to the defaults 186 / 372 / 558 card clocks (half / one / one-and-a-half etu) and `etu_load` is 0. Tracking restarts from the first answer-to-reset byte.
- R2: The first character of a session must be 0x3B. Any other value makes the block dormant, so a later valid exchange changes nothing.
- R3: The answer-to-reset is skipped by counting bytes:
  - T0 gives presence bits for the first interface group in bits 7..4 and the number of historical bytes in bits 3..0.
  - Each interface group is taken in the order A, B, C, D. A D byte gives the next group's presence bits in bits 7..4 and a protocol number in bits 3..0.
  - A trailing check byte is expected only if some D byte gave a nonzero protocol number.
- R4: A request starts with 0xFF. The next byte is the format byte: bits 4, 5 and 6 announce the optional bytes 1, 2 and 3, which follow in that order. A check byte ends the request, and the XOR of all request bytes including it must be 0. The reply uses the same layout.
- R5: The reply must repeat the request's format byte, and also its byte 1 when present. A mismatch makes the block dormant and leaves the counts unchanged.
- R6: A check byte whose XOR over the message is nonzero makes the block dormant and leaves the counts unchanged.
- R7: A character with its error flag set, or with odd parity over its 8 data bits plus parity bit, makes the block dormant.
- R8: On a valid reply that carries byte 1, the counts update and `etu_load` pulses high for one cycle, both on the clock edge that samples the reply's check-byte strobe. The rate comes from byte 1:
  - Bits 7..4 select F: codes 0 and 1 give 372, 2 gives 558, 3 gives 744, 4 gives 1116, 5 gives 1488, 6 gives 1860, 9 gives 512, 10 gives 768, 11 gives 1024, 12 gives 1536, 13 gives 2048.
  - Bits 3..0 give D = 2^(code-1) for codes 1..7.
  - One etu = floor(F/D), half = floor(etu/2), and one-and-a-half = etu + half. For example, 0x94 gives 32 / 64 / 96.
- R9: A byte-1 value whose F or D code is outside the R8 table leaves the counts unchanged and gives no `etu_load` pulse.
- R10: After completing an exchange, the block ignores every further character until the next `sim_rst_rise`. Outside a load or a reset rise, the counts never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sim_rst_rise | input | 1 | One-cycle pulse at a rising edge of the card reset line |
| char_valid | input | 1 | One-cycle strobe: a character was received |
| char_data | input | 8 | Received data bits, as sampled |
| char_par | input | 1 | Received parity bit |
| char_err | input | 1 | Receiver saw the error signal on this character |
| etu_half | output | CNT_W | Card clocks per half etu |
| etu_full | output | CNT_W | Card clocks per etu |
| etu_3half | output | CNT_W | Card clocks per one and a half etu |
| etu_load | output | 1 | One-cycle pulse when new counts were applied |

## Verification
The bench plays whole sessions.

Positive cases:
- A bare answer-to-reset with a one-option request.
- A chained interface-byte answer-to-reset whose historical and check bytes are 0xFF. These bytes expose any miscount, because a skipped byte would then be mistaken for a request start.
- A request carrying byte 2, which checks that optional bytes are skipped correctly.

Negative cases each end in a dormant state, observed by playing a correct exchange afterwards and confirming the defaults hold:
- A wrong first byte.
- A reply that differs in byte 1.
- A bad check byte.
- A parity fault.
- An error flag.
- Unsupported rate codes.

Finally, a second exchange after a successful one shows that the block stays dormant, and a new reset rise shows it re-arms.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int FI_W = 12;

    typedef enum logic [2:0] {
        A_TS, A_T0, A_IFACE, A_HIST, A_TCK, A_DONE, A_DEAD
    } atr_st_e;

    typedef enum logic [2:0] {
        X_WAIT, X_SS, X_P0, X_P1, X_P2, X_P3, X_CK, X_OFF
    } xch_st_e;

    typedef struct packed {
        logic            ok;
        logic [FI_W-1:0] f;
    } fi_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] sh;
    } di_t;

    // clock-rate factor from the upper nibble of the speed byte
    function automatic fi_t fi_decode(input logic [3:0] c);
        fi_t r;
        r.ok = 1'b1;
        case (c)
            4'd0, 4'd1: r.f = 12'd372;
            4'd2:       r.f = 12'd558;
            4'd3:       r.f = 12'd744;
            4'd4:       r.f = 12'd1116;
            4'd5:       r.f = 12'd1488;
            4'd6:       r.f = 12'd1860;
            4'd9:       r.f = 12'd512;
            4'd10:      r.f = 12'd768;
            4'd11:      r.f = 12'd1024;
            4'd12:      r.f = 12'd1536;
            4'd13:      r.f = 12'd2048;
            default: begin
                r.ok = 1'b0;
                r.f  = 12'd372;
            end
        endcase
        return r;
    endfunction

    // baud divisor: powers of two only, expressed as a shift
    function automatic di_t di_decode(input logic [3:0] c);
        di_t r;
        r.ok = (c >= 4'd1) && (c <= 4'd7);
        r.sh = r.ok ? 3'(c - 4'd1) : 3'd0;
        return r;
    endfunction

    function automatic logic par_good(input logic [7:0] d, input logic p);
        return ~(^{d, p});
    endfunction

    function automatic logic [3:0] low_bit(input logic [3:0] y);
        return y & (~y + 4'd1);
    endfunction

    function automatic atr_st_e atr_after_group(input logic [3:0] ny,
                                                input logic [3:0] hist,
                                                input logic       tck);
        if (ny != 4'd0)        return A_IFACE;
        else if (hist != 4'd0) return A_HIST;
        else if (tck)          return A_TCK;
        else                   return A_DONE;
    endfunction

    // next optional byte announced by the format byte, starting at index 'from'
    function automatic xch_st_e pps_next(input logic [7:0] p0, input logic [2:0] from);
        if (from <= 3'd1 && p0[4])      return X_P1;
        else if (from <= 3'd2 && p0[5]) return X_P2;
        else if (from <= 3'd3 && p0[6]) return X_P3;
        else                            return X_CK;
    endfunction

endpackage

// File: rtl/pps_rate_table.sv
module pps_rate_table
    import pps_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [7:0]       fd,
    output logic             ok,
    output logic [CNT_W-1:0] half,
    output logic [CNT_W-1:0] full,
    output logic [CNT_W-1:0] three
);
    fi_t             fi;
    di_t             di;
    logic [FI_W-1:0] q;

    always_comb begin
        fi    = fi_decode(fd[7:4]);
        di    = di_decode(fd[3:0]);
        q     = fi.f >> di.sh;
        ok    = fi.ok & di.ok;
        full  = CNT_W'(q);
        half  = CNT_W'(q >> 1);
        three = CNT_W'(q + (q >> 1));
    end
endmodule

// File: rtl/pps_atr_walker.sv
module pps_atr_walker
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       char_ok,
    input  logic       char_bad,
    input  logic [7:0] char_data,
    output logic       atr_done,
    output logic       atr_dead
);
    atr_st_e    st;
    logic [3:0] y;
    logic [3:0] hist_left;
    logic       tck;
    logic [3:0] lb;
    logic [3:0] ny;
    logic       ntck;

    always_comb begin
        lb   = low_bit(y);
        ny   = (lb == 4'b1000) ? char_data[7:4] : (y & ~lb);
        ntck = tck | ((lb == 4'b1000) && (char_data[3:0] != 4'd0));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st        <= A_TS;
            y         <= 4'd0;
            hist_left <= 4'd0;
            tck       <= 1'b0;
        end else if (char_bad && st != A_DONE && st != A_DEAD) begin
            st <= A_DEAD;
        end else if (char_ok) begin
            case (st)
                A_TS: st <= (char_data == 8'h3B) ? A_T0 : A_DEAD;
                A_T0: begin
                    y         <= char_data[7:4];
                    hist_left <= char_data[3:0];
                    tck       <= 1'b0;
                    st        <= atr_after_group(char_data[7:4], char_data[3:0], 1'b0);
                end
                A_IFACE: begin
                    y   <= ny;
                    tck <= ntck;
                    st  <= atr_after_group(ny, hist_left, ntck);
                end
                A_HIST: begin
                    hist_left <= hist_left - 4'd1;
                    if (hist_left == 4'd1) st <= tck ? A_TCK : A_DONE;
                end
                A_TCK:   st <= A_DONE;
                default: ;
            endcase
        end
    end

    assign atr_done = (st == A_DONE);
    assign atr_dead = (st == A_DEAD);

    // R3
    hist_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (st == A_HIST) |-> (hist_left != 4'd0));

    // R2
    ts_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st == A_TS && char_ok && char_data != 8'h3B && !restart) |=> (st == A_DEAD));
endmodule

// File: rtl/pps_xchg_fsm.sv
module pps_xchg_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       char_ok,
    input  logic       char_bad,
    input  logic [7:0] char_data,
    input  logic       atr_done,
    input  logic       atr_dead,
    output logic       apply,
    output logic [7:0] apply_fd
);
    xch_st_e    st;
    logic       phase;     // 0 request, 1 reply
    logic [7:0] p0_r;
    logic [7:0] p1_r;
    logic [7:0] xacc;

    always_comb begin
        apply    = (st == X_CK) && phase && char_ok &&
                   ((xacc ^ char_data) == 8'h00) && p0_r[4];
        apply_fd = p1_r;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st    <= X_WAIT;
            phase <= 1'b0;
            p0_r  <= 8'h00;
            p1_r  <= 8'h00;
            xacc  <= 8'h00;
        end else if (char_bad || (st == X_WAIT && atr_dead)) begin
            st <= X_OFF;
        end else if (char_ok) begin
            case (st)
                X_WAIT, X_SS: begin
                    if (st == X_SS || atr_done) begin
                        if (char_data == 8'hFF) begin
                            xacc <= 8'hFF;
                            st   <= X_P0;
                        end else begin
                            st <= X_OFF;
                        end
                    end
                end
                X_P0: begin
                    if (phase && char_data != p0_r) st <= X_OFF;
                    else begin
                        if (!phase) p0_r <= char_data;
                        xacc <= xacc ^ char_data;
                        st   <= pps_next(char_data, 3'd1);
                    end
                end
                X_P1: begin
                    if (phase && char_data != p1_r) st <= X_OFF;
                    else begin
                        if (!phase) p1_r <= char_data;
                        xacc <= xacc ^ char_data;
                        st   <= pps_next(p0_r, 3'd2);
                    end
                end
                X_P2: begin
                    xacc <= xacc ^ char_data;
                    st   <= pps_next(p0_r, 3'd3);
                end
                X_P3: begin
                    xacc <= xacc ^ char_data;
                    st   <= pps_next(p0_r, 3'd4);
                end
                X_CK: begin
                    if ((xacc ^ char_data) != 8'h00) st <= X_OFF;
                    else if (!phase) begin
                        phase <= 1'b1;
                        st    <= X_SS;
                    end else begin
                        st <= X_OFF;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    off_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st == X_OFF && !restart) |=> (st == X_OFF));

    // R7
    bad_char_kills_chk: assert property (@(posedge clk) disable iff (rst)
        (char_bad && !restart) |=> (st == X_OFF));
endmodule

// File: rtl/pps_catcher.sv
module pps_catcher
    import pps_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int DEF_ETU = 372
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sim_rst_rise,
    input  logic             char_valid,
    input  logic [7:0]       char_data,
    input  logic             char_par,
    input  logic             char_err,
    output logic [CNT_W-1:0] etu_half,
    output logic [CNT_W-1:0] etu_full,
    output logic [CNT_W-1:0] etu_3half,
    output logic             etu_load
);
    localparam logic [CNT_W-1:0] D_FULL  = CNT_W'(DEF_ETU);
    localparam logic [CNT_W-1:0] D_HALF  = CNT_W'(DEF_ETU / 2);
    localparam logic [CNT_W-1:0] D_THREE = CNT_W'(DEF_ETU + DEF_ETU / 2);

    logic             char_ok;
    logic             char_bad;
    logic             atr_done;
    logic             atr_dead;
    logic             apply;
    logic [7:0]       apply_fd;
    logic             tbl_ok;
    logic [CNT_W-1:0] tbl_half;
    logic [CNT_W-1:0] tbl_full;
    logic [CNT_W-1:0] tbl_three;

    always_comb begin
        char_ok  = char_valid && !char_err && par_good(char_data, char_par);
        char_bad = char_valid && !char_ok;
    end

    pps_atr_walker u_atr (
        .clk       (clk),
        .rst       (rst),
        .restart   (sim_rst_rise),
        .char_ok   (char_ok),
        .char_bad  (char_bad),
        .char_data (char_data),
        .atr_done  (atr_done),
        .atr_dead  (atr_dead)
    );

    pps_xchg_fsm u_xch (
        .clk       (clk),
        .rst       (rst),
        .restart   (sim_rst_rise),
        .char_ok   (char_ok),
        .char_bad  (char_bad),
        .char_data (char_data),
        .atr_done  (atr_done),
        .atr_dead  (atr_dead),
        .apply     (apply),
        .apply_fd  (apply_fd)
    );

    pps_rate_table #(.CNT_W(CNT_W)) u_tbl (
        .fd    (apply_fd),
        .ok    (tbl_ok),
        .half  (tbl_half),
        .full  (tbl_full),
        .three (tbl_three)
    );

    always_ff @(posedge clk) begin
        if (rst || sim_rst_rise) begin
            etu_half  <= D_HALF;
            etu_full  <= D_FULL;
            etu_3half <= D_THREE;
            etu_load  <= 1'b0;
        end else begin
            etu_load <= apply && tbl_ok;
            if (apply && tbl_ok) begin
                etu_half  <= tbl_half;
                etu_full  <= tbl_full;
                etu_3half <= tbl_three;
            end
        end
    end

    // R1
    default_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        sim_rst_rise |=> (etu_full == D_FULL && etu_half == D_HALF &&
                          etu_3half == D_THREE && !etu_load));

    // R8
    load_follows_char_chk: assert property (@(posedge clk) disable iff (rst)
        etu_load |-> $past(char_valid));

    // R10
    hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
        !sim_rst_rise |=> (etu_load || ($stable(etu_full) && $stable(etu_half))));
endmodule

// File: tb/sim_pps_catcher.sv
module sim_pps_catcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sim_rst_rise = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = 8'h00;
    logic        char_par = 1'b0;
    logic        char_err = 1'b0;
    logic [11:0] etu_half;
    logic [11:0] etu_full;
    logic [11:0] etu_3half;
    logic        etu_load;

    int   checks = 0;
    int   errors = 0;
    logic last_load = 1'b0;

    always #5 clk = ~clk;

    pps_catcher u0 (
        .clk(clk), .rst(rst), .sim_rst_rise(sim_rst_rise),
        .char_valid(char_valid), .char_data(char_data),
        .char_par(char_par), .char_err(char_err),
        .etu_half(etu_half), .etu_full(etu_full),
        .etu_3half(etu_3half), .etu_load(etu_load)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_counts(input string tag, input int h, input int f, input int t);
        chk({tag, " half"}, int'(etu_half), h);
        chk({tag, " full"}, int'(etu_full), f);
        chk({tag, " 3half"}, int'(etu_3half), t);
    endtask

    // perr flips the parity bit, eflag raises the error flag
    task automatic send(input logic [7:0] b, input logic perr = 1'b0, input logic eflag = 1'b0);
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = b;
        char_par   = (^b) ^ perr;
        char_err   = eflag;
        @(negedge clk);
        char_valid = 1'b0;
        char_err   = 1'b0;
        last_load  = etu_load;
        repeat (3) @(negedge clk);
    endtask

    task automatic rise();
        @(negedge clk);
        sim_rst_rise = 1'b1;
        @(negedge clk);
        sim_rst_rise = 1'b0;
    endtask

    task automatic bare_atr();
        send(8'h3B);
        send(8'h00);
    endtask

    task automatic pps4(input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] ck);
        send(8'hFF); send(p0); send(p1); send(ck);
    endtask

    task automatic t_reset();
        chk_counts("R1 reset", 186, 372, 558);
        chk("R1 load idle", int'(etu_load), 0);
    endtask

    task automatic t_simple();
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7B);
        chk("R8 no load after request", int'(last_load), 0);
        pps4(8'h10, 8'h94, 8'h7B);
        chk("R8 load pulse", int'(last_load), 1);
        chk("R8 load one cycle", int'(etu_load), 0);
        chk_counts("R8 512/8", 32, 64, 96);
    endtask

    task automatic t_iface();
        rise();
        send(8'h3B); send(8'h92); send(8'h95); send(8'h80);
        send(8'h31); send(8'hFE); send(8'h45);
        send(8'hFF); send(8'h80); send(8'hFF);
        pps4(8'h11, 8'h13, 8'hFD);
        pps4(8'h11, 8'h13, 8'hFD);
        chk("R3 chained ATR load", int'(last_load), 1);
        chk_counts("R3 372/4", 46, 93, 139);
    endtask

    task automatic t_pps2();
        rise();
        bare_atr();
        for (int k = 0; k < 2; k++) begin
            send(8'hFF); send(8'h30); send(8'h96); send(8'h00); send(8'h59);
        end
        chk("R4 optional byte 2 load", int'(last_load), 1);
        chk_counts("R4 512/32", 8, 16, 24);
    endtask

    task automatic t_echo();
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h95, 8'h7A);
        chk("R5 mismatch no load", int'(last_load), 0);
        chk_counts("R5 mismatch", 186, 372, 558);
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h94, 8'h7B);
        chk_counts("R10 dormant after mismatch", 186, 372, 558);
    endtask

    task automatic t_pck();
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7C);
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h94, 8'h7B);
        chk("R6 bad check no load", int'(last_load), 0);
        chk_counts("R6 bad check", 186, 372, 558);
    endtask

    task automatic t_parity();
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7B);
        send(8'hFF); send(8'h10); send(8'h94, 1'b1); send(8'h7B);
        chk_counts("R7 parity fault", 186, 372, 558);
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7B);
        send(8'hFF); send(8'h10); send(8'h94); send(8'h7B, 1'b0, 1'b1);
        chk("R7 error flag no load", int'(last_load), 0);
        chk_counts("R7 error flag", 186, 372, 558);
    endtask

    task automatic t_ts();
        rise();
        send(8'h3F);
        send(8'h00);
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h94, 8'h7B);
        chk_counts("R2 bad first byte", 186, 372, 558);
    endtask

    task automatic t_unsup();
        rise();
        bare_atr();
        pps4(8'h10, 8'h98, 8'h77);
        pps4(8'h10, 8'h98, 8'h77);
        chk("R9 D code 8 no load", int'(last_load), 0);
        chk_counts("R9 D code 8", 186, 372, 558);
        rise();
        bare_atr();
        pps4(8'h10, 8'h74, 8'h9B);
        pps4(8'h10, 8'h74, 8'h9B);
        chk_counts("R9 F code 7", 186, 372, 558);
    endtask

    task automatic t_after();
        rise();
        bare_atr();
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h94, 8'h7B);
        pps4(8'h10, 8'h13, 8'hFC);
        pps4(8'h10, 8'h13, 8'hFC);
        chk("R10 second exchange no load", int'(last_load), 0);
        chk_counts("R10 held", 32, 64, 96);
        rise();
        chk_counts("R1 rise restores", 186, 372, 558);
        chk("R1 rise load low", int'(etu_load), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_simple();
        t_iface();
        t_pps2();
        t_echo();
        t_pck();
        t_parity();
        t_ts();
        t_unsup();
        t_after();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule